// File: doc/BRIEF.md
# Framed Serial Word Receiver with Calibration Lock

This block turns a serial bit stream, already sampled on a recovered clock, into 12-bit parallel words. Every legal word carries two fixed framing bits: its lowest bit is 1 and its highest bit is 0. The receiver slides a 12-bit window over the stream one bit per cycle until it finds an offset whose window meets the framing rule on several words in a row. From then on it delivers one word every 12 cycles with a one-cycle strobe. While aligned it measures how long the link has carried nothing but IDLE words. Once that run reaches the calibration length, it raises a calibrated flag. The flag stays up while the stream keeps its framing, and any framing break sends the receiver back to searching.

The control is a four-state machine. HUNT tests the window on every cycle. A framed window takes it to VERIFY, which re-tests the window once per 12 cycles. VERIFY returns to HUNT on a miss and moves to CALIB after the required count of consecutive framed windows. CALIB delivers words and accumulates the IDLE run. A non-IDLE word clears the run, and the IDLE word that completes it moves the machine to LOCK. CALIB and LOCK both fall back to HUNT on a word that breaks framing. Reset puts the machine in HUNT.

The default IDLE word is 0x03F: bits 0 to 5 are ones and bits 6 to 11 are zeros. A repeated IDLE stream has only one 0-to-1 step per word, so only the true word offset can pass the framing search.

Top module: `framed_deser`

## Requirements
- R1: Serial bits arrive least significant first. Bit i of a delivered word is the (i+1)-th bit received for that word.
- R2: Every delivered word has bit 0 equal to 1 and bit 11 equal to 0.
- R3: After reset or a loss of alignment, the receiver needs LOCK_WORDS (default 4) consecutive framed windows spaced 12 bits apart. Those words are not delivered. The first delivered word is the one that follows them in the stream.
- R4: `word_vld` is high for exactly one cycle per aligned word, with `word` holding that word. It is never high while searching.
- R5: The IDLE run grows by 12 cycles for each delivered word equal to IDLE_WORD (default 0x03F). A delivered non-IDLE word seen before calibration returns the run to zero.
- R6: `cal` rises in the same cycle as the strobe of the IDLE word that brings the run to at least CAL_CYCLES (default 3000, so the 250th consecutive IDLE word).
- R7: Once calibrated, delivered non-IDLE words that keep the framing rule leave `cal` high.
- R8: While aligned, either before or after calibration, a word that breaks the framing rule is not delivered. It clears `cal` at the clock edge where that word would have been delivered. The receiver then restarts the search of R3.
- R9: Reset clears `word`, `word_vld` and `cal` and restarts the search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sdin | input | 1 | Sampled serial data bit |
| word | output | 12 | Last delivered parallel word |
| word_vld | output | 1 | One-cycle strobe per delivered word |
| cal | output | 1 | Calibrated flag, active high |

## Verification
The bench checks the exact count of words consumed by the lock search. A receiver that locked one word early or late would shift every later delivered word against the expected order. It checks that `cal` is still low on the 249th consecutive IDLE word and high on the 250th, and that a data word inserted before that point restarts the count. An off-by-one or a counter that is never cleared would raise the flag on the wrong word. Two framing breaks are sent, one after calibration and one before it. Each must clear the flag, produce no strobe and force a fresh four-word search. Both break words are chosen so that no window straddling them passes the framing rule by accident.

// File: rtl/fdes_pkg.sv
package fdes_pkg;
    typedef enum logic [1:0] {
        S_HUNT   = 2'd0,
        S_VERIFY = 2'd1,
        S_CALIB  = 2'd2,
        S_LOCK   = 2'd3
    } fdes_state_e;
endpackage

// File: rtl/fdes_shift.sv
module fdes_shift #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdin,
    output logic [WORD_W-1:0] win
);
    // newest bit enters at the top, so win[0] is the oldest bit in the window
    always_ff @(posedge clk) begin
        if (rst) win <= '0;
        else     win <= {sdin, win[WORD_W-1:1]};
    end
endmodule

// File: rtl/fdes_frame.sv
module fdes_frame #(
    parameter int                WORD_W    = 12,
    parameter logic [WORD_W-1:0] IDLE_WORD = 12'h03F
) (
    input  logic [WORD_W-1:0] win,
    output logic              frame_ok,
    output logic              is_idle
);
    always_comb begin
        frame_ok = win[0] & ~win[WORD_W-1];
        is_idle  = (win == IDLE_WORD);
    end
endmodule

// File: rtl/fdes_idle_ctr.sv
module fdes_idle_ctr #(
    parameter int WORD_W     = 12,
    parameter int CAL_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic add,
    output logic reach
);
    localparam int CW = $clog2(CAL_CYCLES + WORD_W + 1);

    logic [CW-1:0] cnt;

    // true when one more IDLE word completes the run
    assign reach = (cnt + CW'(WORD_W)) >= CW'(CAL_CYCLES);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (add)   cnt <= reach ? CW'(CAL_CYCLES) : cnt + CW'(WORD_W);
    end

    // R5: the run never exceeds its saturation value
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(CAL_CYCLES));
endmodule

// File: rtl/framed_deser.sv
module framed_deser
    import fdes_pkg::*;
#(
    parameter int                WORD_W     = 12,
    parameter int                LOCK_WORDS = 4,
    parameter int                CAL_CYCLES = 3000,
    parameter logic [WORD_W-1:0] IDLE_WORD  = 12'h03F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdin,
    output logic [WORD_W-1:0] word,
    output logic              word_vld,
    output logic              cal
);
    localparam int BCW = $clog2(WORD_W);
    localparam int GCW = $clog2(LOCK_WORDS + 1);

    fdes_state_e       state, state_n;
    logic [BCW-1:0]    bcnt;
    logic [GCW-1:0]    gcnt;
    logic [WORD_W-1:0] win;
    logic              frame_ok, is_idle, reach;
    logic              boundary, aligned, ctr_clr, ctr_add;

    fdes_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .sdin(sdin), .win(win)
    );

    fdes_frame #(.WORD_W(WORD_W), .IDLE_WORD(IDLE_WORD)) u_frame (
        .win(win), .frame_ok(frame_ok), .is_idle(is_idle)
    );

    fdes_idle_ctr #(.WORD_W(WORD_W), .CAL_CYCLES(CAL_CYCLES)) u_ctr (
        .clk(clk), .rst(rst), .clr(ctr_clr), .add(ctr_add), .reach(reach)
    );

    assign boundary = (state != S_HUNT) && (bcnt == BCW'(WORD_W - 1));
    assign aligned  = (state == S_CALIB) || (state == S_LOCK);
    assign ctr_add  = (state == S_CALIB) && boundary && frame_ok && is_idle;
    assign ctr_clr  = (state != S_CALIB) || (boundary && !(frame_ok && is_idle));

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_HUNT:   if (frame_ok) state_n = S_VERIFY;
            S_VERIFY: if (boundary) begin
                          if (!frame_ok)                          state_n = S_HUNT;
                          else if (gcnt == GCW'(LOCK_WORDS - 1))  state_n = S_CALIB;
                      end
            S_CALIB:  if (boundary) begin
                          if (!frame_ok)                 state_n = S_HUNT;
                          else if (is_idle && reach)     state_n = S_LOCK;
                      end
            S_LOCK:   if (boundary && !frame_ok) state_n = S_HUNT;
        endcase
    end

    // state register and bit/word counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_HUNT;
            bcnt  <= '0;
            gcnt  <= '0;
        end else begin
            state <= state_n;
            if (state == S_HUNT || state_n == S_HUNT) bcnt <= '0;
            else if (boundary)                        bcnt <= '0;
            else                                      bcnt <= bcnt + 1'b1;
            if (state == S_HUNT)                             gcnt <= GCW'(1);
            else if (state == S_VERIFY && boundary && frame_ok) gcnt <= gcnt + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            word     <= '0;
            word_vld <= 1'b0;
            cal      <= 1'b0;
        end else begin
            word_vld <= aligned && boundary && frame_ok;
            if (aligned && boundary && frame_ok) word <= win;
            cal      <= (state_n == S_LOCK);
        end
    end

    // R2: a delivered word always carries the framing bits
    a_r2_vld_framed: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> (word[0] && !word[WORD_W-1]));

    // R4: the strobe lasts a single cycle
    a_r4_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

    // R6: calibration completes only on the strobe of an IDLE word
    a_r6_cal_on_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(cal) |-> (word_vld && word == IDLE_WORD));

    // R8: losing calibration means the search restarted without a delivery
    a_r8_cal_drop_hunt: assert property (@(posedge clk) disable iff (rst)
        $fell(cal) |-> (state == S_HUNT && !word_vld));

    // R9: reset clears the strobe and the flag
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!word_vld && !cal));
endmodule

// File: tb/tb_framed_deser.sv
`timescale 1ns/1ps
module tb_framed_deser;
    localparam logic [11:0] IDLE = 12'h03F;
    localparam logic [11:0] TBL [8] = '{12'h03F, 12'h001, 12'h7FF, 12'h555,
                                        12'h03F, 12'h2A5, 12'h103, 12'h03F};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdin = 1'b0;
    logic [11:0] word;
    logic        word_vld;
    logic        cal;

    int          nchk = 0;
    int          nfail = 0;
    logic [11:0] exq [600];
    logic        exc [600];
    int          ne = 0;
    int          nr = 0;
    int          run = 0;
    logic        mcal = 1'b0;
    string       ph = "R3";
    bit          done = 1'b0;

    framed_deser dut (
        .clk(clk), .rst(rst), .sdin(sdin),
        .word(word), .word_vld(word_vld), .cal(cal)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send_word(input logic [11:0] w);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            sdin = w[i];
        end
    endtask

    task automatic expect_word(input logic [11:0] w);
        if (w == IDLE) run += 12;
        else if (!mcal) run = 0;
        if (run >= 3000) mcal = 1'b1;
        exq[ne] = w;
        exc[ne] = mcal;
        ne++;
        send_word(w);
    endtask

    task automatic lose();
        run  = 0;
        mcal = 1'b0;
    endtask

    task automatic consume_lock();
        for (int i = 0; i < 4; i++) send_word(IDLE);
    endtask

    // output monitor: delivered words in order, framing and calibration flag
    always @(negedge clk) begin
        if (!rst && word_vld && !done) begin
            if (nr < ne) begin
                chk(word == exq[nr], "R1", "delivered word", int'(word), int'(exq[nr]));
                chk(word[0] && !word[11], "R2", "framing bits", int'(word), int'(exq[nr]));
                chk(cal == exc[nr], ph, "cal on delivery", int'(cal), int'(exc[nr]));
            end else begin
                chk(1'b0, "R3", "strobe with no word due", int'(word), 0);
            end
            nr++;
        end
    end

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!word_vld, "R9", "strobe in reset", int'(word_vld), 0);
        chk(!cal, "R9", "cal in reset", int'(cal), 0);
        chk(word == 12'h000, "R9", "word in reset", int'(word), 0);
        rst = 1'b0;

        // R3: four lock words are consumed, the table follows
        ph = "R3";
        consume_lock();
        ph = "R1";
        for (int k = 0; k < 8; k++) expect_word(TBL[k]);

        // R5: a data word restarts the run; R6: flag on the 250th IDLE
        ph = "R5";
        for (int k = 0; k < 200; k++) expect_word(IDLE);
        expect_word(12'h155);
        for (int k = 0; k < 249; k++) expect_word(IDLE);
        ph = "R6";
        expect_word(IDLE);

        // R7: data after calibration keeps the flag
        ph = "R7";
        expect_word(12'h0F1);
        expect_word(12'h7FF);
        expect_word(12'h001);

        // R8: framing break after calibration
        send_word(12'h000);
        lose();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(!cal, "R8", "cal after framing break", int'(cal), 0);
        chk(!word_vld, "R8", "strobe on broken word", int'(word_vld), 0);

        ph = "R8";
        consume_lock();
        expect_word(12'h2A5);
        expect_word(IDLE);
        // framing break before calibration
        send_word(12'h03E);
        lose();
        consume_lock();
        expect_word(12'h555);

        // R9: reset in mid traffic
        repeat (3) @(negedge clk);
        chk(nr == ne, "R4", "strobes before reset", nr, ne);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!word_vld, "R9", "strobe after reset", int'(word_vld), 0);
        chk(!cal, "R9", "cal after reset", int'(cal), 0);
        chk(word == 12'h000, "R9", "word after reset", int'(word), 0);
        rst = 1'b0;
        lose();
        ph = "R9";
        consume_lock();
        expect_word(12'h3C1);
        repeat (4) @(negedge clk);
        chk(nr == ne, "R4", "total strobes", nr, ne);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule